// File: doc/BRIEF.md
# Serial LCD Command/Data Framer

This block feeds a graphic LCD controller that listens on a three-byte serial protocol. A host hands it one payload byte at a time over a valid/ready handshake. The block wraps each byte in a frame. The first byte is a sync byte that tells the display whether the payload is a command or data. The payload itself follows, split across two bytes: each byte carries one nibble in its upper half and zeros in its lower half. The frame goes out on a clock-polarity-0, clock-phase-0 serial link whose clock rate is set by a divider select and a double-speed flag.

A sticky register-select mode decides whether each byte is sent as a command or as data. The mode comes out of reset in command mode and changes only when the host writes it. A mode write can arrive in the same cycle as a byte, and that byte then uses the new mode. After the last bit of every frame, the block waits for a fixed settle time before it accepts the next byte, so that the display has time to execute the byte. The chip select is active high and follows an enable input. The display reset line is passed straight through.

Top module: `serial_lcd_framer`

## Requirements
- R1: Each accepted byte D produces exactly 24 bits on `mosi`, MSB first, sampled on rising `sclk`. The first byte is the sync byte: 0xF8 when the latched mode is command (0) and 0xFA when it is data (1). The second byte is {D[7:4], 4'b0000}. The third byte is {D[3:0], 4'b0000}.
- R2: The mode register is 0 (command) after reset. A cycle with `modeWe` high loads it from `modeData`. It keeps its value until the next write.
- R3: When `modeWe` is high in the cycle a byte is accepted, that byte is framed with the new `modeData` value.
- R4: `sclk` is low whenever the block is not busy, and `mosi` is low whenever the block is not busy. `mosi` never changes in the cycle in which `sclk` rises.
- R5: The `sclk` period in system clocks is 4, 16, 64 or 128 for `divSel` = 0, 1, 2 or 3. When `dblSpeed` is high, the period is half of that.
- R6: `divSel` and `dblSpeed` are sampled when a byte is accepted. Changing them during a frame does not change that frame's `sclk` period.
- R7: `busy` is high for exactly 24*P + SETTLE_CYCLES cycles per frame, where P is the `sclk` period. `inReady` is low for that whole time. A new frame cannot start until at least SETTLE_CYCLES cycles after the last falling `sclk` edge.
- R8: A byte is accepted only on a cycle with `inValid` and `inReady` both high. The block holds that byte for the whole frame. `inData` and `inValid` have no effect while the block is busy.
- R9: `cs` equals `enable` delayed by one clock. `cs` is 0 in reset.
- R10: `lcdRstOut` equals `lcdRstIn` with no register in the path.
- R11: In reset, `sclk`, `mosi` and `busy` are 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Interface enable, drives chip select |
| divSel | input | 2 | Clock divider select (/4, /16, /64, /128) |
| dblSpeed | input | 1 | Halves the selected divisor |
| modeWe | input | 1 | Write strobe for the register-select mode |
| modeData | input | 1 | New mode: 0 command, 1 data |
| inValid | input | 1 | Payload byte valid |
| inData | input | 8 | Payload byte |
| inReady | output | 1 | Block can accept a byte |
| busy | output | 1 | Frame or settle delay in progress |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| cs | output | 1 | Active-high chip select |
| lcdRstIn | input | 1 | Display reset request |
| lcdRstOut | output | 1 | Display reset to the panel |

## Verification
A mode write and a byte acceptance can fall on the same clock edge. The bench provokes this by raising `modeWe` and `inValid` on the same cycle while the stored mode still holds the other value. It judges the result from the sync byte captured on the wire (it must be 0xFA after a switch to data mode). It then checks that a following byte sent without a mode write keeps the new mode. Two other coincidences are also driven on purpose. In one, a divider change lands in the middle of a frame. In the other, `inValid` is held high through a whole frame and its settle delay.

// File: rtl/lcd_framer_pkg.sv
package lcd_framer_pkg;

  localparam int FRAME_BITS = 24;
  localparam int BIT_CNT_W  = $clog2(FRAME_BITS);
  localparam int HALF_W     = 7;
  localparam logic [7:0] SYNC_CMD  = 8'hF8;
  localparam logic [7:0] SYNC_DATA = 8'hFA;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_SETTLE = 2'd2
  } framerState_t;

  typedef struct packed {
    logic load;
    logic shiftEn;
    logic settleEn;
  } ctrlStrobe_t;

  // Half period of sclk in system clocks.
  function automatic logic [HALF_W-1:0] halfPeriod(input logic [1:0] sel, input logic dbl);
    logic [HALF_W-1:0] base;
    case (sel)
      2'd0:    base = 7'd2;
      2'd1:    base = 7'd8;
      2'd2:    base = 7'd32;
      default: base = 7'd64;
    endcase
    return dbl ? (base >> 1) : base;
  endfunction

  function automatic logic [FRAME_BITS-1:0] buildFrame(input logic rs, input logic [7:0] d);
    return {(rs ? SYNC_DATA : SYNC_CMD), d[7:4], 4'h0, d[3:0], 4'h0};
  endfunction

endpackage

// File: rtl/lcd_framer_dp.sv
module lcd_framer_dp
  import lcd_framer_pkg::*;
#(
  parameter int SETTLE_CYCLES = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t strobe,
  input  logic [7:0]  inData,
  input  logic        rsEff,
  input  logic [1:0]  divSel,
  input  logic        dblSpeed,
  output logic        sclk,
  output logic        mosi,
  output logic        frameDone,
  output logic        settleDone
);

  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);
  localparam logic [SETTLE_W-1:0]  SETTLE_LAST = SETTLE_W'(SETTLE_CYCLES - 1);

  logic [FRAME_BITS-1:0] shiftReg;
  logic [BIT_CNT_W-1:0]  bitCnt;
  logic [HALF_W-1:0]     divCnt;
  logic [HALF_W-1:0]     halfLen;
  logic [SETTLE_W-1:0]   settleCnt;
  logic                  halfTick;

  assign halfTick   = strobe.shiftEn && (divCnt == halfLen - 7'd1);
  assign frameDone  = halfTick && sclk && (bitCnt == LAST_BIT);
  assign settleDone = strobe.settleEn && (settleCnt == SETTLE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      divCnt   <= '0;
      halfLen  <= 7'd2;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
    end else if (strobe.load) begin
      logic [FRAME_BITS-1:0] f;
      f = buildFrame(rsEff, inData);
      mosi     <= f[FRAME_BITS-1];
      shiftReg <= f << 1;
      bitCnt   <= '0;
      divCnt   <= '0;
      halfLen  <= halfPeriod(divSel, dblSpeed);
      sclk     <= 1'b0;
    end else if (strobe.shiftEn) begin
      if (halfTick) begin
        divCnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bitCnt == LAST_BIT) begin
            mosi <= 1'b0;
          end else begin
            mosi     <= shiftReg[FRAME_BITS-1];
            shiftReg <= shiftReg << 1;
            bitCnt   <= bitCnt + 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frameDone) begin
      settleCnt <= '0;
    end else if (strobe.settleEn && !settleDone) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

endmodule

// File: rtl/lcd_framer_ctrl.sv
module lcd_framer_ctrl
  import lcd_framer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        inValid,
  input  logic        modeWe,
  input  logic        modeData,
  input  logic        frameDone,
  input  logic        settleDone,
  output ctrlStrobe_t strobe,
  output logic        inReady,
  output logic        busy,
  output logic        rsEff,
  output logic        cs
);

  framerState_t state;
  framerState_t stateNext;
  logic         modeReg;
  logic         accept;

  assign inReady = (state == ST_IDLE);
  assign busy    = !inReady;
  assign accept  = inReady && inValid;
  assign rsEff   = modeWe ? modeData : modeReg;

  always_comb begin
    strobe.load     = accept;
    strobe.shiftEn  = (state == ST_SHIFT);
    strobe.settleEn = (state == ST_SETTLE);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (accept)     stateNext = ST_SHIFT;
      ST_SHIFT:  if (frameDone)  stateNext = ST_SETTLE;
      ST_SETTLE: if (settleDone) stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      modeReg <= 1'b0;
      cs      <= 1'b0;
    end else begin
      state <= stateNext;
      cs    <= enable;
      if (modeWe) modeReg <= modeData;
    end
  end

endmodule

// File: rtl/serial_lcd_framer.sv
module serial_lcd_framer
  import lcd_framer_pkg::*;
#(
  parameter int SETTLE_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] divSel,
  input  logic       dblSpeed,
  input  logic       modeWe,
  input  logic       modeData,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       inReady,
  output logic       busy,
  output logic       sclk,
  output logic       mosi,
  output logic       cs,
  input  logic       lcdRstIn,
  output logic       lcdRstOut
);

  ctrlStrobe_t strobe;
  logic        rsEff;
  logic        frameDone;
  logic        settleDone;

  assign lcdRstOut = lcdRstIn;

  lcd_framer_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .inValid    (inValid),
    .modeWe     (modeWe),
    .modeData   (modeData),
    .frameDone  (frameDone),
    .settleDone (settleDone),
    .strobe     (strobe),
    .inReady    (inReady),
    .busy       (busy),
    .rsEff      (rsEff),
    .cs         (cs)
  );

  lcd_framer_dp #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .inData     (inData),
    .rsEff      (rsEff),
    .divSel     (divSel),
    .dblSpeed   (dblSpeed),
    .sclk       (sclk),
    .mosi       (mosi),
    .frameDone  (frameDone),
    .settleDone (settleDone)
  );

endmodule

// File: rtl/serial_lcd_framer_chk.sv
module serial_lcd_framer_chk #(
  parameter int SETTLE_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic inValid,
  input logic inReady,
  input logic busy,
  input logic sclk,
  input logic mosi,
  input logic cs
);

  logic        sclkQ;
  logic [31:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclkQ  <= 1'b0;
      gapCnt <= 32'(SETTLE_CYCLES);
    end else begin
      sclkQ <= sclk;
      if (sclkQ && !sclk)               gapCnt <= 32'd1;
      else if (gapCnt != 32'hFFFF_FFFF) gapCnt <= gapCnt + 32'd1;
    end
  end

  AST_MOSI_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi)); // R4
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !mosi)); // R4
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !inReady); // R7
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inReady) |-> (gapCnt >= 32'(SETTLE_CYCLES))); // R7
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(inValid && inReady)); // R8
  AST_CS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs == $past(enable))); // R9

endmodule

bind serial_lcd_framer serial_lcd_framer_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (.*);

// File: tb/serial_lcd_framer_tb.sv
module serial_lcd_framer_tb;

  localparam int SETTLE = 100;
  localparam int NVEC   = 8;
  // {rs, data, divSel, dblSpeed}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 8'hA5, 2'd0, 1'b0}, {1'b1, 8'h3C, 2'd1, 1'b0},
    {1'b0, 8'h01, 2'd2, 1'b0}, {1'b1, 8'hF0, 2'd3, 1'b0},
    {1'b1, 8'h7E, 2'd0, 1'b1}, {1'b0, 8'hC3, 2'd1, 1'b1},
    {1'b1, 8'h00, 2'd2, 1'b1}, {1'b0, 8'hFF, 2'd3, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0] divSel = 2'd0;
  logic dblSpeed = 1'b0, modeWe = 1'b0, modeData = 1'b0;
  logic inValid = 1'b0, lcdRstIn = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inReady, busy, sclk, mosi, cs, lcdRstOut;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  serial_lcd_framer #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .divSel(divSel), .dblSpeed(dblSpeed),
    .modeWe(modeWe), .modeData(modeData), .inValid(inValid), .inData(inData),
    .inReady(inReady), .busy(busy), .sclk(sclk), .mosi(mosi), .cs(cs),
    .lcdRstIn(lcdRstIn), .lcdRstOut(lcdRstOut)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] expFrame(input logic rs, input logic [7:0] d);
    return {(rs ? 8'hFA : 8'hF8), d[7:4], 4'h0, d[3:0], 4'h0};
  endfunction

  function automatic int expPeriod(input logic [1:0] s, input logic dbl);
    int p;
    p = (s == 2'd0) ? 4 : (s == 2'd1) ? 16 : (s == 2'd2) ? 64 : 128;
    return dbl ? p / 2 : p;
  endfunction

  task automatic setMode(input logic v);
    @(negedge clk); modeWe = 1'b1; modeData = v;
    @(negedge clk); modeWe = 1'b0;
  endtask

  task automatic runFrame(input logic [7:0] d, input bit doMode, input logic modeVal,
                          input bit holdValid, input bit changeDiv,
                          output logic [23:0] bits, output int nBits, output int period,
                          output int busyLen, output int readyViol);
    logic prevS;
    int lastRise, prevRise;
    @(negedge clk);
    inValid = 1'b1; inData = d;
    if (doMode) begin modeWe = 1'b1; modeData = modeVal; end
    @(negedge clk);
    modeWe = 1'b0;
    if (holdValid) inData = 8'h5A; else inValid = 1'b0;
    bits = '0; nBits = 0; busyLen = 0; readyViol = 0;
    prevS = 1'b0; lastRise = 0; prevRise = 0;
    while (busy && busyLen < 100000) begin
      busyLen++;
      if (inReady) readyViol++;
      if (sclk && !prevS) begin
        bits = {bits[22:0], mosi};
        nBits++;
        prevRise = lastRise;
        lastRise = busyLen;
      end
      prevS = sclk;
      if (changeDiv && busyLen == 10) divSel = divSel ^ 2'b11;
      @(negedge clk);
    end
    inValid = 1'b0;
    period = lastRise - prevRise;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] bits;
    int nBits, period, busyLen, rv;

    repeat (3) @(negedge clk);
    check(!sclk && !mosi, "R11 lines idle in reset", {sclk, mosi}, 0);
    check(!busy && inReady, "R11 ready in reset", {busy, inReady}, 1);
    check(cs == 1'b0, "R9 cs low in reset", cs, 0);
    rst_n = 1'b1;

    lcdRstIn = 1'b1; #1;
    check(lcdRstOut == 1'b1, "R10 reset pass high", lcdRstOut, 1);
    lcdRstIn = 1'b0; #1;
    check(lcdRstOut == 1'b0, "R10 reset pass low", lcdRstOut, 0);

    @(negedge clk); enable = 1'b1;
    #1 check(cs == 1'b0, "R9 cs lags enable", cs, 0);
    @(negedge clk);
    check(cs == 1'b1, "R9 cs follows enable", cs, 1);

    // R2: default command mode without any write
    runFrame(8'h96, 0, 0, 0, 0, bits, nBits, period, busyLen, rv);
    check(bits == expFrame(1'b0, 8'h96), "R2 default command frame", bits, expFrame(1'b0, 8'h96));

    for (int i = 0; i < NVEC; i++) begin
      logic rs; logic [7:0] d; int p;
      rs = VEC[i][11]; d = VEC[i][10:3];
      divSel = VEC[i][2:1]; dblSpeed = VEC[i][0];
      p = expPeriod(divSel, dblSpeed);
      setMode(rs);
      runFrame(d, 0, 0, 0, 0, bits, nBits, period, busyLen, rv);
      check(bits == expFrame(rs, d), "R1 frame content", bits, expFrame(rs, d));
      check(nBits == 24, "R1 bit count", nBits, 24);
      check(period == p, "R5 sclk period", period, p);
      check(busyLen == 24 * p + SETTLE, "R7 busy length", busyLen, 24 * p + SETTLE);
      check(rv == 0, "R7 ready low while busy", rv, 0);
    end

    // R3: mode write in the acceptance cycle
    divSel = 2'd0; dblSpeed = 1'b0;
    setMode(1'b0);
    runFrame(8'h4B, 1, 1'b1, 0, 0, bits, nBits, period, busyLen, rv);
    check(bits == expFrame(1'b1, 8'h4B), "R3 same-cycle mode write", bits, expFrame(1'b1, 8'h4B));
    // R2: mode sticks
    runFrame(8'h2D, 0, 0, 0, 0, bits, nBits, period, busyLen, rv);
    check(bits == expFrame(1'b1, 8'h2D), "R2 mode sticky", bits, expFrame(1'b1, 8'h2D));

    // R8: inValid held with new data during the frame
    runFrame(8'hE1, 0, 0, 1, 0, bits, nBits, period, busyLen, rv);
    check(bits == expFrame(1'b1, 8'hE1), "R8 byte latched", bits, expFrame(1'b1, 8'hE1));
    check(rv == 0, "R8 not ready while busy", rv, 0);
    @(negedge clk);
    check(!busy && !sclk, "R8 no extra frame", {busy, sclk}, 0);

    // R6: divider change mid-frame
    divSel = 2'd0; dblSpeed = 1'b0;
    runFrame(8'h88, 0, 0, 0, 1, bits, nBits, period, busyLen, rv);
    check(period == 4, "R6 period held mid-frame", period, 4);
    check(busyLen == 96 + SETTLE, "R6 busy length held", busyLen, 96 + SETTLE);
    check(bits == expFrame(1'b1, 8'h88), "R6 frame intact", bits, expFrame(1'b1, 8'h88));
    check(!sclk && !mosi, "R4 lines idle after frame", {sclk, mosi}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule